// File: doc/BRIEF.md
# Accumulator Add/Subtract Execution Unit

This unit performs the add and subtract work of an accumulator-based microcontroller core. The caller presents an operation code, a width select (byte, word or long word), the current 32-bit accumulator (high half AH, low half AL), a second operand and the current carry flag. One clock later the unit returns the value to be written, a flag that says whether that value goes to the accumulator or back to the operand's location, and fresh N, Z, V and C flags. The caller does instruction fetch, address generation and cycle timing.

Binary add and subtract come in plain and carry-in forms. The carry-in forms use only byte and word width. There are forms that write to memory, and forms that take both operands from the two accumulator halves. Byte-wide packed-decimal add and subtract are also supported. A byte result that goes to the accumulator clears the upper byte of AL and keeps AH. A word result that goes to the accumulator replaces AL and keeps AH.

Top module: `acc_arith_unit`

## Requirements
- R1: Op codes are 0 ADD, 1 SUB, 2 ADDC, 3 SUBC, 4 ADD-to-memory, 5 SUB-to-memory, 6 byte half-add with carry, 7 byte half-subtract with borrow, 8 word half-add, 9 word half-subtract, 10 decimal add, 11 decimal subtract. Width codes are 0 byte, 1 word, 2 long. A legal request with `op_vld` high raises `res_vld` on the following cycle.
- R2: Codes 0 and 1 compute A+opnd and A−opnd at the selected width. A is AL's low byte, AL, or the full accumulator, depending on width. The result targets the accumulator (`res_to_mem`=0).
- R3: Codes 2 and 3 compute A+opnd+C and A−opnd−C, in byte or word width only.
- R4: Codes 4 and 5 compute opnd+A and opnd−A, set `res_to_mem`=1, and put the result zero-extended in `res_data`.
- R5: An accumulator-target result is returned as the full new accumulator. Byte gives {AH, 8'h00, r8}. Word gives {AH, r16}. Long gives r32.
- R6: Codes 6 and 7 (byte only) compute AH[7:0]+AL[7:0]+C and AH[7:0]−AL[7:0]−C into the accumulator.
- R7: Codes 8 and 9 (word only) compute AH+AL and AH−AL, and the 16-bit result goes to AL.
- R8: Codes 10 and 11 (byte only) treat AH[7:0] and AL[7:0] as two packed BCD digits and compute AH+AL+C and AH−AL−C in decimal. C is the decimal carry or borrow and V is 0.
- R9: N is the result's top bit at the active width. Z is set exactly when the result at the active width is zero.
- R10: For binary forms, C is the carry out of the active width on add and the borrow on subtract. V flags two's-complement overflow at that width.
- R11: These requests are ignored: long width with codes 2 or 3, any width but byte for codes 6, 7, 10 and 11, any width but word for codes 8 and 9, width code 3, and op codes 12–15. `res_vld` stays low and all other outputs hold their values.
- R12: With `op_vld` low, `res_vld` is low on the next cycle and the data, target and flag outputs hold.
- R13: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_vld | input | 1 | Request strobe |
| op_code | input | 4 | Operation code (R1) |
| op_width | input | 2 | Width code (R1) |
| opnd | input | 32 | Second operand supplied by the caller |
| acc | input | 32 | Accumulator, AH in [31:16], AL in [15:0] |
| c_in | input | 1 | Current carry flag |
| res_vld | output | 1 | Result valid, one cycle after the request |
| res_data | output | 32 | New accumulator or operand-location value |
| res_to_mem | output | 1 | 1: write to operand location, 0: write to accumulator |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry / borrow flag |

## Verification
The bench uses the default parameters: a 32-bit accumulator with the decimal adjuster present. This gives byte, word and long lanes of 8, 16 and 32 bits, and two BCD digits per decimal byte. With these values the bench can reach the nine-to-zero digit rollover, the borrow through 00, and the signed-overflow and carry edges at all three widths. Because the decimal path is built in, codes 10 and 11 are legal here, so their results are checked instead of being rejected.

// File: rtl/acc_arith_pkg.sv
package acc_arith_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_SUB   = 4'd1,
      OP_ADDC  = 4'd2,
      OP_SUBC  = 4'd3,
      OP_ADDM  = 4'd4,
      OP_SUBM  = 4'd5,
      OP_ADCHL = 4'd6,
      OP_SBCHL = 4'd7,
      OP_ADDHL = 4'd8,
      OP_SUBHL = 4'd9,
      OP_DADD  = 4'd10,
      OP_DSUB  = 4'd11
   } aop_e;

   typedef enum logic [1:0] {
      W_BYTE = 2'd0,
      W_WORD = 2'd1,
      W_LONG = 2'd2,
      W_RSVD = 2'd3
   } awid_e;

   typedef enum logic [1:0] {
      SRC_ACC_OPND = 2'd0,
      SRC_OPND_ACC = 2'd1,
      SRC_HI_LO    = 2'd2
   } asrc_e;

   typedef struct packed {
      logic  legal;
      logic  sub;
      logic  use_c;
      logic  to_mem;
      logic  dec;
      asrc_e src;
   } actl_t;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } aflags_t;

endpackage

// File: rtl/acc_op_decode.sv
module acc_op_decode
   import acc_arith_pkg::*;
#(
   parameter bit DEC_EN = 1'b1
) (
   input  logic [3:0] op_code,
   input  logic [1:0] op_width,
   output actl_t      ctl
);

   always_comb begin
      ctl        = '0;
      ctl.src    = SRC_ACC_OPND;
      unique case (op_code)
         OP_ADD, OP_SUB: begin
            ctl.legal = (op_width != W_RSVD);
            ctl.sub   = (op_code == OP_SUB);
         end
         OP_ADDC, OP_SUBC: begin
            ctl.legal = (op_width == W_BYTE) || (op_width == W_WORD);
            ctl.sub   = (op_code == OP_SUBC);
            ctl.use_c = 1'b1;
         end
         OP_ADDM, OP_SUBM: begin
            ctl.legal  = (op_width != W_RSVD);
            ctl.sub    = (op_code == OP_SUBM);
            ctl.to_mem = 1'b1;
            ctl.src    = SRC_OPND_ACC;
         end
         OP_ADCHL, OP_SBCHL: begin
            ctl.legal = (op_width == W_BYTE);
            ctl.sub   = (op_code == OP_SBCHL);
            ctl.use_c = 1'b1;
            ctl.src   = SRC_HI_LO;
         end
         OP_ADDHL, OP_SUBHL: begin
            ctl.legal = (op_width == W_WORD);
            ctl.sub   = (op_code == OP_SUBHL);
            ctl.src   = SRC_HI_LO;
         end
         OP_DADD, OP_DSUB: begin
            ctl.legal = DEC_EN && (op_width == W_BYTE);
            ctl.sub   = (op_code == OP_DSUB);
            ctl.use_c = 1'b1;
            ctl.dec   = 1'b1;
            ctl.src   = SRC_HI_LO;
         end
         default: ctl.legal = 1'b0;
      endcase
   end

endmodule

// File: rtl/acc_oprnd_sel.sv
module acc_oprnd_sel
   import acc_arith_pkg::*;
#(
   parameter int ACC_W = 32
) (
   input  asrc_e            src,
   input  logic [ACC_W-1:0] acc,
   input  logic [ACC_W-1:0] opnd,
   output logic [ACC_W-1:0] x,
   output logic [ACC_W-1:0] y
);

   localparam int HALF_W = ACC_W / 2;

   always_comb begin
      unique case (src)
         SRC_OPND_ACC: begin
            x = opnd;
            y = acc;
         end
         SRC_HI_LO: begin
            x = {{HALF_W{1'b0}}, acc[ACC_W-1:HALF_W]};
            y = {{HALF_W{1'b0}}, acc[HALF_W-1:0]};
         end
         default: begin
            x = acc;
            y = opnd;
         end
      endcase
   end

endmodule

// File: rtl/acc_bin_core.sv
module acc_bin_core #(
   parameter int ACC_W = 32
) (
   input  logic [ACC_W-1:0] x,
   input  logic [ACC_W-1:0] y,
   input  logic [1:0]       wsel,
   input  logic             sub,
   input  logic             cin,
   output logic [ACC_W-1:0] r,
   output logic             c_out,
   output logic             v_out
);

   localparam int HALF_W = ACC_W / 2;
   localparam int BYTE_W = ACC_W / 4;

   logic [ACC_W-1:0]  yi;
   logic              ci;
   logic [BYTE_W:0]   sum_b;
   logic [HALF_W:0]   sum_w;
   logic [ACC_W:0]    sum_l;
   logic              raw_c, xm, ym, rm;

   assign yi    = sub ? ~y : y;
   assign ci    = sub ? ~cin : cin;
   assign sum_b = {1'b0, x[BYTE_W-1:0]} + {1'b0, yi[BYTE_W-1:0]} + {{BYTE_W{1'b0}}, ci};
   assign sum_w = {1'b0, x[HALF_W-1:0]} + {1'b0, yi[HALF_W-1:0]} + {{HALF_W{1'b0}}, ci};
   assign sum_l = {1'b0, x} + {1'b0, yi} + {{ACC_W{1'b0}}, ci};

   always_comb begin
      unique case (wsel)
         2'd0: begin
            r     = {{(ACC_W-BYTE_W){1'b0}}, sum_b[BYTE_W-1:0]};
            raw_c = sum_b[BYTE_W];
            xm    = x[BYTE_W-1];
            ym    = yi[BYTE_W-1];
            rm    = sum_b[BYTE_W-1];
         end
         2'd1: begin
            r     = {{HALF_W{1'b0}}, sum_w[HALF_W-1:0]};
            raw_c = sum_w[HALF_W];
            xm    = x[HALF_W-1];
            ym    = yi[HALF_W-1];
            rm    = sum_w[HALF_W-1];
         end
         default: begin
            r     = sum_l[ACC_W-1:0];
            raw_c = sum_l[ACC_W];
            xm    = x[ACC_W-1];
            ym    = yi[ACC_W-1];
            rm    = sum_l[ACC_W-1];
         end
      endcase
   end

   assign c_out = sub ? ~raw_c : raw_c;
   assign v_out = (xm == ym) && (rm != xm);

endmodule

// File: rtl/acc_bcd_adj.sv
module acc_bcd_adj #(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] a,
   input  logic [BYTE_W-1:0] b,
   input  logic              sub,
   input  logic              cin,
   output logic [BYTE_W-1:0] r,
   output logic              c_out
);

   localparam int N_DIG = BYTE_W / 4;

   logic [N_DIG:0] cy;
   assign cy[0] = cin;

   for (genvar d = 0; d < N_DIG; d++) begin : g_dig
      logic [4:0] raw;
      logic [4:0] fix;
      logic       ovf;
      always_comb begin
         if (sub) begin
            raw = {1'b0, a[4*d +: 4]} - {1'b0, b[4*d +: 4]} - {4'd0, cy[d]};
            ovf = raw[4];
            fix = ovf ? (raw - 5'd6) : raw;
         end else begin
            raw = {1'b0, a[4*d +: 4]} + {1'b0, b[4*d +: 4]} + {4'd0, cy[d]};
            ovf = (raw > 5'd9);
            fix = ovf ? (raw + 5'd6) : raw;
         end
      end
      assign r[4*d +: 4] = fix[3:0];
      assign cy[d+1]     = ovf;
   end

   assign c_out = cy[N_DIG];

endmodule

// File: rtl/acc_arith_unit.sv
module acc_arith_unit
   import acc_arith_pkg::*;
#(
   parameter int ACC_W  = 32,
   parameter bit DEC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_vld,
   input  logic [3:0]       op_code,
   input  logic [1:0]       op_width,
   input  logic [ACC_W-1:0] opnd,
   input  logic [ACC_W-1:0] acc,
   input  logic             c_in,
   output logic             res_vld,
   output logic [ACC_W-1:0] res_data,
   output logic             res_to_mem,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_v,
   output logic             flag_c
);

   localparam int HALF_W = ACC_W / 2;
   localparam int BYTE_W = ACC_W / 4;

   if ((ACC_W % 32) != 0 || ACC_W < 32) begin : g_bad_width
      $error("acc_arith_unit: ACC_W must be a positive multiple of 32");
   end

   actl_t            ctl;
   logic [ACC_W-1:0] opx, opy, bin_r, sel_r, nxt_data;
   logic             bin_c, bin_v, cin_eff;
   logic [BYTE_W-1:0] dec_r;
   logic             dec_c;
   aflags_t          nxt_f, flg_q;
   logic             fire;

   acc_op_decode #(.DEC_EN(DEC_EN)) u_dec (
      .op_code (op_code),
      .op_width(op_width),
      .ctl     (ctl)
   );

   acc_oprnd_sel #(.ACC_W(ACC_W)) u_sel (
      .src (ctl.src),
      .acc (acc),
      .opnd(opnd),
      .x   (opx),
      .y   (opy)
   );

   assign cin_eff = ctl.use_c & c_in;

   acc_bin_core #(.ACC_W(ACC_W)) u_bin (
      .x    (opx),
      .y    (opy),
      .wsel (op_width),
      .sub  (ctl.sub),
      .cin  (cin_eff),
      .r    (bin_r),
      .c_out(bin_c),
      .v_out(bin_v)
   );

   if (DEC_EN) begin : g_dec
      acc_bcd_adj #(.BYTE_W(BYTE_W)) u_bcd (
         .a    (opx[BYTE_W-1:0]),
         .b    (opy[BYTE_W-1:0]),
         .sub  (ctl.sub),
         .cin  (cin_eff),
         .r    (dec_r),
         .c_out(dec_c)
      );
   end else begin : g_nodec
      assign dec_r = '0;
      assign dec_c = 1'b0;
   end

   assign sel_r = ctl.dec ? {{(ACC_W-BYTE_W){1'b0}}, dec_r} : bin_r;

   always_comb begin
      nxt_f.v = ctl.dec ? 1'b0 : bin_v;
      nxt_f.c = ctl.dec ? dec_c : bin_c;
      unique case (op_width)
         2'd0: begin
            nxt_f.n = sel_r[BYTE_W-1];
            nxt_f.z = (sel_r[BYTE_W-1:0] == '0);
            nxt_data = ctl.to_mem ? sel_r
                     : {acc[ACC_W-1:HALF_W], {(HALF_W-BYTE_W){1'b0}}, sel_r[BYTE_W-1:0]};
         end
         2'd1: begin
            nxt_f.n = sel_r[HALF_W-1];
            nxt_f.z = (sel_r[HALF_W-1:0] == '0);
            nxt_data = ctl.to_mem ? sel_r : {acc[ACC_W-1:HALF_W], sel_r[HALF_W-1:0]};
         end
         default: begin
            nxt_f.n = sel_r[ACC_W-1];
            nxt_f.z = (sel_r == '0);
            nxt_data = sel_r;
         end
      endcase
   end

   assign fire = op_vld && ctl.legal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_vld    <= 1'b0;
         res_data   <= '0;
         res_to_mem <= 1'b0;
         flg_q      <= '0;
      end else begin
         res_vld <= fire;
         if (fire) begin
            res_data   <= nxt_data;
            res_to_mem <= ctl.to_mem;
            flg_q      <= nxt_f;
         end
      end
   end

   assign flag_n = flg_q.n;
   assign flag_z = flg_q.z;
   assign flag_v = flg_q.v;
   assign flag_c = flg_q.c;

   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_vld |=> !res_vld && $stable(res_data) && $stable(res_to_mem) && $stable(flag_c));

   // R11
   long_carry_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_vld && (op_code == 4'd2 || op_code == 4'd3) && op_width == 2'd2 |=> !res_vld && $stable(res_data));

   // R4
   mem_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_vld && (op_code == 4'd4 || op_code == 4'd5) && op_width != 2'd3 |=> res_vld && res_to_mem);

   // R5
   byte_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_vld && op_width == 2'd0 && (op_code == 4'd0 || op_code == 4'd2 || op_code == 4'd6)
      |=> res_data[HALF_W-1:BYTE_W] == '0 && res_data[ACC_W-1:HALF_W] == $past(acc[ACC_W-1:HALF_W]));

   // R9
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld && flag_z |-> res_data[BYTE_W-1:0] == '0);

   // R8
   dec_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_vld && DEC_EN && op_width == 2'd0 && (op_code == 4'd10 || op_code == 4'd11)
      && acc[3:0] <= 4'd9 && acc[7:4] <= 4'd9
      && acc[HALF_W+3:HALF_W] <= 4'd9 && acc[HALF_W+7:HALF_W+4] <= 4'd9
      |=> res_data[3:0] <= 4'd9 && res_data[7:4] <= 4'd9 && !flag_v);

endmodule

// File: tb/acc_arith_unit_tb.sv
`timescale 1ns/1ps
module acc_arith_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        op_vld;
   logic [3:0]  op_code;
   logic [1:0]  op_width;
   logic [31:0] opnd, acc;
   logic        c_in;
   logic        res_vld, res_to_mem, flag_n, flag_z, flag_v, flag_c;
   logic [31:0] res_data;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   acc_arith_unit dut_i (
      .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_code(op_code),
      .op_width(op_width), .opnd(opnd), .acc(acc), .c_in(c_in),
      .res_vld(res_vld), .res_data(res_data), .res_to_mem(res_to_mem),
      .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
   );

   // expected state
   logic        e_vld = 0, e_mem = 0, e_n = 0, e_z = 0, e_v = 0, e_c = 0;
   logic [31:0] e_data = 0;
   string       t_data = "R13", t_flag = "R13", t_cv = "R13";

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   function automatic bit is_legal(input int op, input int w);
      case (op)
         0, 1, 4, 5: return w != 3;
         2, 3:       return w == 0 || w == 1;
         6, 7, 10, 11: return w == 0;
         8, 9:       return w == 1;
         default:    return 0;
      endcase
   endfunction

   function automatic int bcd2i(input logic [7:0] b);
      return b[7:4] * 10 + b[3:0];
   endfunction

   task automatic compare();
      chk((t_data == "R11" || t_data == "R12") ? t_data : "R1", {31'd0, res_vld}, {31'd0, e_vld});
      chk(t_data, res_data, e_data);
      chk(t_data, {31'd0, res_to_mem}, {31'd0, e_mem});
      chk(t_flag, {30'd0, flag_n, flag_z}, {30'd0, e_n, e_z});
      chk(t_cv,   {30'd0, flag_v, flag_c}, {30'd0, e_v, e_c});
   endtask

   task automatic model(input int op, input int w, input logic [31:0] od,
                        input logic [31:0] ac, input logic ci, input logic vld);
      longint x, y, s, mask, r;
      int     wb;
      bit     sub, mem, use_c, dec;
      if (!vld || !is_legal(op, w)) begin
         e_vld = 0;
         t_data = vld ? "R11" : "R12";
         t_flag = t_data;
         t_cv   = t_data;
         return;
      end
      wb    = (w == 0) ? 8 : (w == 1) ? 16 : 32;
      mask  = (longint'(1) << wb) - 1;
      sub   = op[0];
      mem   = (op == 4 || op == 5);
      use_c = (op == 2 || op == 3 || op == 6 || op == 7 || op == 10 || op == 11);
      dec   = (op == 10 || op == 11);
      if (mem) begin x = od; y = ac; end
      else if (op >= 6) begin x = ac[31:16]; y = ac[15:0]; end
      else begin x = ac; y = od; end
      x = x & mask;
      y = y & mask;
      if (dec) begin
         int dv;
         dv = sub ? bcd2i(x[7:0]) - bcd2i(y[7:0]) - int'(ci)
                  : bcd2i(x[7:0]) + bcd2i(y[7:0]) + int'(ci);
         e_c = sub ? (dv < 0) : (dv >= 100);
         if (dv < 0) dv += 100;
         dv = dv % 100;
         r = (dv / 10) * 16 + dv % 10;
         e_v = 0;
         t_cv = "R8";
      end else begin
         s = sub ? x - y - ((use_c && ci) ? 1 : 0) : x + y + ((use_c && ci) ? 1 : 0);
         r = s & mask;
         e_c = sub ? (s < 0) : ((s >> wb) & 1);
         if (sub) e_v = (x[wb-1] != y[wb-1]) && (r[wb-1] != x[wb-1]);
         else     e_v = (x[wb-1] == y[wb-1]) && (r[wb-1] != x[wb-1]);
         t_cv = "R10";
      end
      e_n = r[wb-1];
      e_z = (r == 0);
      t_flag = dec ? "R8" : "R9";
      e_vld = 1;
      e_mem = mem;
      if (mem)         e_data = r[31:0];
      else if (w == 0) e_data = {ac[31:16], 8'h00, r[7:0]};
      else if (w == 1) e_data = {ac[31:16], r[15:0]};
      else             e_data = r[31:0];
      case (op)
         0, 1:   t_data = (w == 2) ? "R2" : "R5";
         2, 3:   t_data = "R3";
         4, 5:   t_data = "R4";
         6, 7:   t_data = "R6";
         8, 9:   t_data = "R7";
         default: t_data = "R8";
      endcase
   endtask

   task automatic step(input int op, input int w, input logic [31:0] od,
                       input logic [31:0] ac, input logic ci, input logic vld);
      @(negedge clk);
      compare();
      op_vld   = vld;
      op_code  = op[3:0];
      op_width = w[1:0];
      opnd     = od;
      acc      = ac;
      c_in     = ci;
      model(op, w, od, ac, ci, vld);
   endtask

   initial begin
      #(200_000 * 5);
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 0; op_vld = 0; op_code = 0; op_width = 0; opnd = 0; acc = 0; c_in = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R13 reset state checked by the first compare
      step(0, 0, 32'h1, 32'h1234_AB7F, 0, 1);           // R2/R5 byte overflow 7F+1
      step(1, 1, 32'h1, 32'h5555_0000, 0, 1);           // R10 word borrow 0-1
      step(0, 2, 32'h1, 32'hFFFF_FFFF, 0, 1);           // R9 long carry to zero
      step(1, 2, 32'h1, 32'h8000_0000, 0, 1);           // R10 long signed overflow
      step(2, 0, 32'hFF, 32'h0000_0000, 1, 1);          // R3 byte add with carry
      step(3, 1, 32'h0, 32'hAAAA_0000, 1, 1);           // R3 word borrow from C
      step(4, 1, 32'h0000_1234, 32'hFFFF_0001, 0, 1);   // R4 memory add
      step(5, 0, 32'h0000_0010, 32'h0000_0020, 0, 1);   // R4 memory subtract
      step(6, 0, 32'h0, 32'h77FF_EE80, 1, 1);           // R6 AH+AL+C
      step(7, 0, 32'h0, 32'h0010_0010, 1, 1);           // R6 AH-AL-C
      step(8, 1, 32'h0, 32'h8000_8000, 0, 1);           // R7 word AH+AL
      step(9, 1, 32'h0, 32'h0003_0005, 0, 1);           // R7 word AH-AL
      step(10, 0, 32'h0, 32'h0099_0001, 0, 1);          // R8 99+01 -> 00 carry
      step(10, 0, 32'h0, 32'h0045_0038, 1, 1);          // R8 45+38+1
      step(11, 0, 32'h0, 32'h0000_0001, 0, 1);          // R8 00-01 -> 99 borrow
      step(11, 0, 32'h0, 32'h0050_0025, 1, 1);          // R8 50-25-1
      step(2, 2, 32'h5, 32'h5, 1, 1);                   // R11 long with carry rejected
      step(8, 0, 32'h5, 32'h5, 0, 1);                   // R11 half add at byte rejected
      step(0, 3, 32'h5, 32'h5, 0, 1);                   // R11 width code 3
      step(15, 0, 32'h5, 32'h5, 0, 1);                  // R11 unused op
      step(0, 0, 32'h5, 32'h5, 0, 0);                   // R12 idle
      for (int i = 0; i < 3000; i++) begin
         int op, w;
         logic [31:0] a;
         op = $urandom_range(0, 15);
         w  = $urandom_range(0, 3);
         a  = $urandom;
         if (op == 10 || op == 11) begin
            a[3:0]   = 4'($urandom_range(0, 9));
            a[7:4]   = 4'($urandom_range(0, 9));
            a[19:16] = 4'($urandom_range(0, 9));
            a[23:20] = 4'($urandom_range(0, 9));
         end
         step(op, w, $urandom, a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) != 0));
      end
      step(0, 0, 0, 0, 0, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule